// File: doc/BRIEF.md
# JTAG Debug Port Access Responder

This block is the target-side end of a debug link that sits behind a standard IEEE 1149.1 test access port. A host drives TCK, TMS and TDI; the block runs the 16-state TAP controller, holds a 4-bit instruction register and, depending on the instruction, presents one of four data paths. The first path is a 32-bit identification value. The second and third are 35-bit access scans to the debug-port registers or the access-port registers. The fourth is a 35-bit cancel scan. Any other instruction selects a one-bit bypass path.

Access scans are pipelined. Each scan shifts out a 3-bit acknowledge and a 32-bit word that holds the result of an earlier read, while it shifts in a request for a new access. That access starts when the scan passes through Update-DR. Access-port operations take a number of TCK cycles set by the `ap_lat` input. A scan that is captured while one of them is still running gets WAIT and is then ignored. Sticky overrun and fault flags in the control/status register block further access-port traffic until the host writes a 1 to the flag to clear it.

Top module: `jtag_dp_responder`

## Requirements
- R1: In reset or in Test-Logic-Reset, the instruction becomes identification (0xE). A data scan under that instruction shifts out the 32-bit `IDCODE_VAL` least significant bit first.
- R2: Capture-IR loads 4'b0001. The instruction codes are 0x8 cancel, 0xA debug-port access, 0xB access-port access and 0xE identification. Every other code selects a 1-bit bypass register, which captures 0 and delays TDI by one shift.
- R3: An access scan is 35 bits long and shifts least significant bit first. Bit 0 is RnW (1 = read), bits [2:1] are the register address A[3:2] and bits [34:3] are the write data. The bits captured into [2:0] are the acknowledge, where 3'b010 means OK and 3'b001 means WAIT.
- R4: Bits [34:3] of a captured scan hold the most recent posted read result. A debug-port read of address 3 (read buffer) returns that result and changes nothing.
- R5: The debug-port registers are address 1 (control/status) and address 2 (bank select). Control/status has overrun-detect enable at bit 0 (read/write), sticky overrun at bit 1 and sticky fault at bit 5, and writing 1 to bit 1 or bit 5 clears that flag. Bank select keeps bits [7:4]. Address 0 reads 0.
- R6: An access-port access started at Update-DR stays pending for `ap_lat`+1 TCK rising edges. Any access scan captured while it is pending returns WAIT.
- R7: The update of a scan that returned WAIT has no effect. If overrun detect is enabled, it sets sticky overrun.
- R8: An access-port scan is dropped while either sticky flag is set.
- R9: An access-port access reaches word {bank[BANK_W-1:0], A[3:2]}. A bank value of 2^BANK_W or higher sets sticky fault and performs no access.
- R10: A cancel scan whose data bit 0 is 1 drops the pending access-port access. If the cancel lands on the same TCK edge as the access completes, the cancel wins and the write is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| ap_lat | input | LAT_W | Extra TCK cycles an access-port operation takes |
| tdo | output | 1 | Serial data out (shift states only, else 0) |

## Verification
Two events can fall on the same TCK edge: the end of a pending access-port write and the Update-DR of a cancel scan. The bench starts an access-port write and then runs an instruction scan followed by a 35-bit cancel scan. These add up to exactly 50 edges, so with `ap_lat` set to 49 the two events coincide. With `ap_lat` set to 48 the write completes one edge before the cancel. A later read-back of the target word must show the old value in the first case and the new value in the second.

// File: rtl/dp_pkg.sv
// Package: TAP state encoding, instruction codes and acknowledge codes
// shared by the debug-port responder and its submodules.
package dp_pkg;
    typedef enum logic [3:0] {
        ST_TLR, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [3:0] INS_ABORT  = 4'h8;
    localparam logic [3:0] INS_DPACC  = 4'hA;
    localparam logic [3:0] INS_APACC  = 4'hB;
    localparam logic [3:0] INS_IDCODE = 4'hE;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;
endpackage

// File: rtl/dp_tap_fsm.sv
// Module: dp_tap_fsm
// The 16-state IEEE 1149.1 TAP controller. It moves on every rising TCK
// edge according to TMS. Assumes rst_n is synchronous to tck.
module dp_tap_fsm
    import dp_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    // Next-state table of the TAP controller
    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    // State register, reset to Test-Logic-Reset
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end
endmodule

// File: rtl/dp_ap_regs.sv
// Module: dp_ap_regs
// Stand-in access-port register file. It accepts one access at a time and
// keeps it pending for lat+1 TCK edges. A write is committed when the access
// completes, and a read result is offered on done/rdata at that edge. A
// cancel drops the pending access and beats a completion on the same edge.
// Assumes the caller never issues while busy is high.
module dp_ap_regs #(
    parameter int BANK_W = 1,
    parameter int LAT_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W  = BANK_W + 2,
    localparam int NWORDS = 1 << IDX_W
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              rnw,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              abort,
    input  logic [LAT_W-1:0]  lat,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic              pend_q;
    logic [LAT_W-1:0]  cnt_q;
    logic              op_rnw_q;
    logic [IDX_W-1:0]  op_idx_q;
    logic [DATA_W-1:0] op_wd_q;
    logic [DATA_W-1:0] mem_q [NWORDS];
    logic              finish;

    assign finish = pend_q && (cnt_q == '0) && !abort;
    assign busy   = pend_q;
    assign done   = finish && op_rnw_q;
    assign rdata  = mem_q[op_idx_q];

    // Track the pending access: launch, count down, complete or cancel
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            op_rnw_q <= 1'b0;
            op_idx_q <= '0;
            op_wd_q  <= '0;
        end else if (abort) begin
            pend_q <= 1'b0;
        end else if (issue) begin
            pend_q   <= 1'b1;
            cnt_q    <= lat;
            op_rnw_q <= rnw;
            op_idx_q <= idx;
            op_wd_q  <= wdata;
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Register file storage; a write lands when its access completes
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
        end else if (finish && !op_rnw_q) begin
            mem_q[op_idx_q] <= op_wd_q;
        end
    end

    AST_NO_ISSUE_BUSY: assert property (@(posedge tck) disable iff (!rst_n)
        issue |-> !pend_q);  // R6
    AST_ABORT_NO_COMMIT: assert property (@(posedge tck) disable iff (!rst_n)
        (abort && pend_q && !op_rnw_q) |=> $stable(mem_q[$past(op_idx_q)]));  // R10
endmodule

// File: rtl/jtag_dp_responder.sv
// Module: jtag_dp_responder
// Debug port behind a TAP. It decodes the instruction register, shifts the
// identification, access, cancel and bypass data registers, returns OK or
// WAIT, posts read results for the next scan, and keeps the sticky overrun
// and fault flags. Assumes a synchronous active-low reset on tck.
module jtag_dp_responder
    import dp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h3C0D_E0F1,
    parameter int          BANK_W     = 1,
    parameter int          LAT_W      = 8
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [LAT_W-1:0] ap_lat,
    output logic             tdo
);
    localparam int DATA_W = 32;
    localparam int SCAN_W = DATA_W + 3;
    localparam int IDX_W  = BANK_W + 2;

    tap_state_e        state;
    logic [3:0]        ir_q, ir_sh_q;
    logic [SCAN_W-1:0] sr_q;
    logic [DATA_W-1:0] posted_q;
    logic              cap_wait_q, ordet_q, orun_q, err_q;
    logic [3:0]        bank_q;
    logic              is_acc, is_long, upd, upd_ok, bank_ok;
    logic              ap_issue, ap_fault, ap_abort, orun_set;
    logic              ap_busy, ap_done;
    logic [DATA_W-1:0] ap_rdata;
    logic              req_rnw;
    logic [1:0]        req_a;
    logic [DATA_W-1:0] req_wd;

    dp_tap_fsm u_tap (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

    assign is_acc   = (ir_q == INS_DPACC) || (ir_q == INS_APACC);
    assign is_long  = is_acc || (ir_q == INS_ABORT);
    assign upd      = (state == ST_UPD_DR);
    assign req_rnw  = sr_q[0];
    assign req_a    = sr_q[2:1];
    assign req_wd   = sr_q[SCAN_W-1:3];
    assign upd_ok   = upd && is_acc && !cap_wait_q;
    assign bank_ok  = (bank_q >> BANK_W) == 4'd0;
    assign ap_issue = upd_ok && (ir_q == INS_APACC) && !orun_q && !err_q && bank_ok;
    assign ap_fault = upd_ok && (ir_q == INS_APACC) && !orun_q && !err_q && !bank_ok;
    assign ap_abort = upd && (ir_q == INS_ABORT) && sr_q[3];
    assign orun_set = upd && is_acc && cap_wait_q && ordet_q;

    dp_ap_regs #(.BANK_W(BANK_W), .LAT_W(LAT_W), .DATA_W(DATA_W)) u_ap (
        .tck(tck), .rst_n(rst_n), .issue(ap_issue), .rnw(req_rnw),
        .idx({bank_q[BANK_W-1:0], req_a}), .wdata(req_wd), .abort(ap_abort),
        .lat(ap_lat), .busy(ap_busy), .done(ap_done), .rdata(ap_rdata)
    );

    // Instruction register: capture, shift, update, forced in Test-Logic-Reset
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ir_q    <= INS_IDCODE;
            ir_sh_q <= '0;
        end else begin
            case (state)
                ST_TLR:    ir_q    <= INS_IDCODE;
                ST_CAP_IR: ir_sh_q <= 4'b0001;
                ST_SH_IR:  ir_sh_q <= {tdi, ir_sh_q[3:1]};
                ST_UPD_IR: ir_q    <= ir_sh_q;
                default: ;
            endcase
        end
    end

    // Data shift register: capture per instruction, then shift LSB first
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sr_q       <= '0;
            cap_wait_q <= 1'b0;
        end else if (state == ST_CAP_DR) begin
            cap_wait_q <= ap_busy;
            if (is_long)                  sr_q <= {posted_q, ap_busy ? ACK_WAIT : ACK_OK};
            else if (ir_q == INS_IDCODE)  sr_q <= {3'b000, IDCODE_VAL};
            else                          sr_q <= '0;
        end else if (state == ST_SH_DR) begin
            if (is_long)                  sr_q <= {tdi, sr_q[SCAN_W-1:1]};
            else if (ir_q == INS_IDCODE)  sr_q <= {3'b000, tdi, sr_q[DATA_W-1:1]};
            else                          sr_q <= {{(SCAN_W-1){1'b0}}, tdi};
        end
    end

    // Debug-port registers, sticky flags and the posted read result
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            posted_q <= '0;
            ordet_q  <= 1'b0;
            orun_q   <= 1'b0;
            err_q    <= 1'b0;
            bank_q   <= '0;
        end else begin
            if (ap_done) posted_q <= ap_rdata;
            if (orun_set) orun_q <= 1'b1;
            if (ap_fault) err_q  <= 1'b1;
            if (upd_ok && (ir_q == INS_DPACC)) begin
                case (req_a)
                    2'd0: if (req_rnw) posted_q <= '0;
                    2'd1: if (req_rnw) begin
                        posted_q <= {26'd0, err_q, 3'd0, orun_q, ordet_q};
                    end else begin
                        ordet_q <= req_wd[0];
                        if (req_wd[1]) orun_q <= 1'b0;
                        if (req_wd[5]) err_q  <= 1'b0;
                    end
                    2'd2: if (req_rnw) posted_q <= {24'd0, bank_q, 4'd0};
                          else         bank_q   <= req_wd[7:4];
                    default: ;
                endcase
            end
        end
    end

    // Serial output: low bit of whichever register is shifting
    always_comb begin
        if (state == ST_SH_IR)      tdo = ir_sh_q[0];
        else if (state == ST_SH_DR) tdo = sr_q[0];
        else                        tdo = 1'b0;
    end

    AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> (ir_q == INS_IDCODE));  // R1
    AST_WAIT_WHEN_BUSY: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && is_long && ap_busy) |=> (sr_q[2:0] == ACK_WAIT));  // R6
    AST_ORUN_ON_WAIT: assert property (@(posedge tck) disable iff (!rst_n)
        (upd && is_acc && cap_wait_q && ordet_q) |=> orun_q);  // R7
    AST_RDBUF_NO_EFFECT: assert property (@(posedge tck) disable iff (!rst_n)
        (upd && ir_q == INS_DPACC && !cap_wait_q && sr_q[2:0] == 3'b111) |=> $stable(posted_q));  // R4
    AST_ERR_STICKY: assert property (@(posedge tck) disable iff (!rst_n)
        (err_q && !(upd_ok && ir_q == INS_DPACC && sr_q[2:0] == 3'b010 && sr_q[8])) |=> err_q);  // R9
endmodule

// File: tb/test_jtag_dp_responder.sv
// Directed bench: one task per scenario, each checks its own results.
module test_jtag_dp_responder;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [7:0] ap_lat = 8'd1;
    logic       tdo;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         fin = 1'b0;

    localparam logic [31:0] IDV = 32'h3C0D_E0F1;

    jtag_dp_responder #(.IDCODE_VAL(IDV), .BANK_W(1), .LAT_W(8)) i_jtag_dp_responder (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .ap_lat(ap_lat), .tdo(tdo)
    );

    always #10 tck = ~tck;

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        o   = tdo;
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o);
            cap[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic dr_scan(input int n, input logic [34:0] din, output logic [34:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic acc(input logic [1:0] a, input logic rnw, input logic [31:0] d,
                       output logic [2:0] ack, output logic [31:0] q);
        logic [34:0] o;
        dr_scan(35, {d, a, rnw}, o);
        ack = o[2:0];
        q   = o[34:3];
    endtask

    task automatic sel_ir(input logic [3:0] code);
        logic [3:0] c;
        ir_scan(code, c);
    endtask

    task automatic dp_write(input logic [1:0] a, input logic [31:0] d);
        logic [2:0] k; logic [31:0] q;
        sel_ir(4'hA);
        acc(a, 1'b0, d, k, q);
    endtask

    task automatic dp_read(input logic [1:0] a, output logic [31:0] q);
        logic [2:0] k; logic [31:0] x;
        sel_ir(4'hA);
        acc(a, 1'b1, 32'd0, k, x);
        acc(2'd3, 1'b1, 32'd0, k, q);
    endtask

    task automatic ap_write(input logic [1:0] a, input logic [31:0] d);
        logic [2:0] k; logic [31:0] q;
        sel_ir(4'hB);
        acc(a, 1'b0, d, k, q);
        idle(4);
    endtask

    task automatic ap_read(input logic [1:0] a, output logic [31:0] q);
        logic [2:0] k; logic [31:0] x;
        sel_ir(4'hB);
        acc(a, 1'b1, 32'd0, k, x);
        sel_ir(4'hA);
        acc(2'd3, 1'b1, 32'd0, k, q);
    endtask

    task automatic t_reset_id;
        logic [34:0] o; logic [3:0] c; logic x;
        check("R1 tdo idle in reset", {34'd0, tdo}, 35'd0);
        dr_scan(32, 35'd0, o);
        check("R1 idcode after reset", o, {3'd0, IDV});
        ir_scan(4'hF, c);
        check("R2 ir capture", {31'd0, c}, 35'd1);
        dr_scan(8, {27'd0, 8'b1011_0110}, o);
        check("R2 bypass delay", o, {27'd0, 8'b0110_1100});
        for (int i = 0; i < 5; i++) tick(1, 0, x);
        tick(0, 0, x);
        dr_scan(32, 35'd0, o);
        check("R1 idcode after tlr", o, {3'd0, IDV});
    endtask

    task automatic t_dp_regs;
        logic [31:0] q; logic [2:0] k; logic [31:0] x;
        dp_write(2'd2, 32'h0000_0010);
        sel_ir(4'hA);
        acc(2'd2, 1'b1, 32'd0, k, x);
        check("R3 ack ok", {32'd0, k}, 35'd2);
        acc(2'd3, 1'b1, 32'd0, k, q);
        check("R5 select readback", {3'd0, q}, 35'h10);
        acc(2'd3, 1'b1, 32'd0, k, q);
        check("R4 rdbuff unchanged", {3'd0, q}, 35'h10);
        check("R4 posted on scan", {3'd0, q}, 35'h10);
        dp_read(2'd0, q);
        check("R5 addr0 zero", {3'd0, q}, 35'd0);
        dp_write(2'd2, 32'h0);
    endtask

    task automatic t_ap_basic;
        logic [31:0] q;
        ap_lat = 8'd1;
        ap_write(2'd1, 32'hCAFE_0001);
        ap_write(2'd2, 32'h0000_1234);
        dp_write(2'd2, 32'h10);
        ap_write(2'd1, 32'h0000_0055);
        dp_write(2'd2, 32'h00);
        ap_read(2'd1, q);
        check("R9 bank0 word1", {3'd0, q}, {3'd0, 32'hCAFE_0001});
        dp_write(2'd2, 32'h10);
        ap_read(2'd1, q);
        check("R9 bank1 word1", {3'd0, q}, 35'h55);
        dp_write(2'd2, 32'h00);
    endtask

    task automatic t_wait;
        logic [31:0] q; logic [2:0] k; logic [31:0] x;
        dp_write(2'd1, 32'h1);
        ap_lat = 8'd100;
        sel_ir(4'hB);
        acc(2'd3, 1'b0, 32'h0000_AAAA, k, x);
        acc(2'd3, 1'b0, 32'h0000_BBBB, k, x);
        check("R6 wait while pending", {32'd0, k}, 35'd1);
        idle(120);
        ap_lat = 8'd1;
        dp_read(2'd1, q);
        check("R7 overrun set", {3'd0, q}, 35'h3);
        ap_write(2'd3, 32'h0000_CCCC);
        dp_write(2'd1, 32'h3);
        dp_read(2'd1, q);
        check("R5 overrun cleared", {3'd0, q}, 35'h1);
        ap_read(2'd3, q);
        check("R8 R7 discarded writes", {3'd0, q}, 35'hAAAA);
    endtask

    task automatic t_fault;
        logic [31:0] q;
        dp_write(2'd2, 32'h30);
        ap_write(2'd0, 32'h0000_7777);
        dp_read(2'd1, q);
        check("R9 bank fault", {3'd0, q}, 35'h21);
        dp_write(2'd2, 32'h00);
        ap_write(2'd3, 32'h0000_DDDD);
        dp_write(2'd1, 32'h21);
        dp_read(2'd1, q);
        check("R5 fault cleared", {3'd0, q}, 35'h1);
        ap_read(2'd3, q);
        check("R8 dropped under fault", {3'd0, q}, 35'hAAAA);
        ap_read(2'd0, q);
        check("R9 faulting write absent", {3'd0, q}, 35'h0);
    endtask

    task automatic abort_run(input logic [7:0] lat, input logic [31:0] d);
        logic [2:0] k; logic [31:0] x; logic [34:0] o;
        ap_lat = lat;
        sel_ir(4'hB);
        acc(2'd2, 1'b0, d, k, x);
        sel_ir(4'h8);
        dr_scan(35, {32'd1, 3'd0}, o);
        ap_lat = 8'd1;
        idle(60);
    endtask

    task automatic t_abort;
        logic [31:0] q;
        abort_run(8'd49, 32'h0000_9999);
        ap_read(2'd2, q);
        check("R10 abort wins same edge", {3'd0, q}, 35'h1234);
        abort_run(8'd48, 32'h0000_7777);
        ap_read(2'd2, q);
        check("R10 completes before abort", {3'd0, q}, 35'h7777);
    endtask

    initial begin
        repeat (3) @(posedge tck);
        @(negedge tck);
        rst_n = 1'b1;
        tms   = 1'b0;
        @(posedge tck);
        t_reset_id();
        t_dp_regs();
        t_ap_basic();
        t_wait();
        t_fault();
        t_abort();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule